// File: doc/BRIEF.md
# Register Command Table Sequencer

The sequencer runs a list of register operations held in a small local table of 32-bit words and plays each one out on a register bus. Software or a loader fills the table through a plain write port. A start pulse then gives a base word address and a word budget. From that point the block fetches one command at a time and carries it out:

- a direct write;
- an indirect write that also carries an index-space selector;
- a masked read-modify-write;
- a blocking poll that re-reads a register until a masked value matches;
- an end marker.

Commands differ in length, and the word pointer moves past each command by exactly its own length. Each run finishes with a one-cycle `done` pulse. The `resp` output then holds the outcome:

- OK when the end marker was reached;
- incomplete when the run hit an unknown command, ran out of its word budget, or gave up on a poll.

The register bus uses a request/ready handshake. `bus_wr` or `bus_rd` is a request. Once raised, the request holds together with `bus_addr`, `bus_space`, `bus_indirect` and `bus_wdata`, all unchanged, until a cycle in which `bus_ready` is high. The transfer takes place in that cycle, and for a read `bus_rdata` must be valid in that same cycle. The slave applies back-pressure simply by keeping `bus_ready` low. The block never raises both requests at once.

Top module: `cmdtab_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_wr` and `bus_rd` are 0 and `resp` is 0; no bus request appears while `busy` is 0.
- R2: Header type code 0 (bits 31:28) is a 2-word direct write: a write to address bits 27:0 of the header with the second word as data, `bus_indirect` 0.
- R3: Type code 8 is a 2-word indirect write: `bus_addr` is header bits 19:0 zero-extended, `bus_space` is header bits 27:20, `bus_indirect` is 1, and the data is the second word.
- R4: Type code 3 is a 3-word read-modify-write. Word 2 is the data and word 3 is the mask. The block reads the register, then writes back (old & ~mask) | (data & mask).
- R5: Type code 2 is a 3-word poll. Word 2 is the mask and word 3 is the wait value. The block repeats reads until (read & mask) == wait, then goes on with the next command.
- R6: If a poll sees POLL_TRIES reads in a row that do not match, the run stops with `resp` = 2 (incomplete).
- R7: Type code 15 is a 1-word end. It stops the run with `resp` = 1 (OK).
- R8: Any other type code stops the run with `resp` = 2, and no bus request is made for that word.
- R9: A command whose full length would go beyond the `run_words` budget counted from the base is not executed, and the run stops with `resp` = 2.
- R10: The word pointer advances by the command length (2, 3, 3, 2, 1 for codes 0, 3, 2, 8, 15), wrapping at the table size.
- R11: A request and its address, space and data stay unchanged until `bus_ready`; `bus_wr` and `bus_rd` are never high together.
- R12: `done` is a one-cycle pulse issued with `busy` already low; `start` while busy is ignored; `start` while idle raises `busy` the next cycle and clears `resp` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_base | input | AW | Table word address of the first command |
| run_words | input | AW+1 | Word budget for the run |
| tbl_we | input | 1 | Table load write enable |
| tbl_waddr | input | AW | Table load address |
| tbl_wdata | input | 32 | Table load data |
| bus_addr | output | 28 | Register address |
| bus_space | output | 8 | Index-space selector (indirect writes) |
| bus_indirect | output | 1 | Current request is an indirect write |
| bus_wdata | output | 32 | Register write data |
| bus_wr | output | 1 | Write request |
| bus_rd | output | 1 | Read request |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Transfer completes this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| resp | output | 2 | 0 none, 1 OK, 2 incomplete |

## Verification
The assertions check on every cycle the parts of the bus handshake that hold for any table. A stalled request must keep its address, space and data, and reads and writes must be exclusive. `done` must be a single-cycle pulse that comes with a non-zero response and `busy` low, and an idle start must raise `busy`.

Other behaviour depends on table contents and on values computed from the data, so only the bench's scenarios can show it. That covers the per-command operand order, the merged value of a read-modify-write, the poll's read count and timeout, the budget cut-off and the pointer wrap. The bench compares these against a reference walk of the same table, with a slave that stalls at random.

// File: rtl/cmdtab_pkg.sv
package cmdtab_pkg;
  localparam int WORD_W     = 32;
  localparam int DIR_OFFS_W = 28;
  localparam int IND_OFFS_W = 20;
  localparam int SPACE_W    = 8;

  localparam logic [3:0] OPC_WRITE  = 4'h0;
  localparam logic [3:0] OPC_POLL   = 4'h2;
  localparam logic [3:0] OPC_RMW    = 4'h3;
  localparam logic [3:0] OPC_IWRITE = 4'h8;
  localparam logic [3:0] OPC_END    = 4'hF;

  localparam logic [1:0] RESP_NONE       = 2'd0;
  localparam logic [1:0] RESP_OK         = 2'd1;
  localparam logic [1:0] RESP_INCOMPLETE = 2'd2;

  typedef enum logic [2:0] {CMD_WRITE, CMD_RMW, CMD_POLL, CMD_END, CMD_BAD} cmd_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_WRITE, ST_RMW_RD, ST_POLL} seq_state_e;

  typedef struct packed {
    cmd_kind_e               kind;
    logic [1:0]              len;
    logic                    indirect;
    logic [DIR_OFFS_W-1:0]   addr;
    logic [SPACE_W-1:0]      space;
  } cmd_info_t;
endpackage

// File: rtl/cmdtab_decode.sv
module cmdtab_decode
  import cmdtab_pkg::*;
(
  input  logic [WORD_W-1:0] hdr,
  output cmd_info_t         info
);
  logic [3:0] opc;
  assign opc = hdr[WORD_W-1 -: 4];

  always_comb begin
    info          = '0;
    info.kind     = CMD_BAD;
    info.len      = 2'd1;
    case (opc)
      OPC_WRITE: begin
        info.kind = CMD_WRITE;
        info.len  = 2'd2;
        info.addr = hdr[DIR_OFFS_W-1:0];
      end
      OPC_IWRITE: begin
        info.kind     = CMD_WRITE;
        info.len      = 2'd2;
        info.indirect = 1'b1;
        info.addr     = DIR_OFFS_W'(hdr[IND_OFFS_W-1:0]);
        info.space    = hdr[IND_OFFS_W +: SPACE_W];
      end
      OPC_RMW: begin
        info.kind = CMD_RMW;
        info.len  = 2'd3;
        info.addr = hdr[DIR_OFFS_W-1:0];
      end
      OPC_POLL: begin
        info.kind = CMD_POLL;
        info.len  = 2'd3;
        info.addr = hdr[DIR_OFFS_W-1:0];
      end
      OPC_END: begin
        info.kind = CMD_END;
        info.len  = 2'd1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmdtab_table_mem.sv
module cmdtab_table_mem #(
  parameter int AW  = 6,
  parameter int DW  = 32,
  parameter int NRD = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rbase,
  output logic [DW-1:0] rdata [NRD]
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra       = rbase + AW'(g);
    assign rdata[g] = mem[ra];
  end
endmodule

// File: rtl/cmdtab_poll_budget.sv
module cmdtab_poll_budget #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] misses;

  assign expire = miss && (misses == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     misses <= '0;
    else if (clear) misses <= '0;
    else if (miss)  misses <= misses + 1'b1;
  end
endmodule

// File: rtl/cmdtab_seq.sv
module cmdtab_seq
  import cmdtab_pkg::*;
#(
  parameter int AW         = 6,
  parameter int POLL_TRIES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-1:0]         start_base,
  input  logic [AW:0]           run_words,
  input  logic                  tbl_we,
  input  logic [AW-1:0]         tbl_waddr,
  input  logic [WORD_W-1:0]     tbl_wdata,
  output logic [DIR_OFFS_W-1:0] bus_addr,
  output logic [SPACE_W-1:0]    bus_space,
  output logic                  bus_indirect,
  output logic [WORD_W-1:0]     bus_wdata,
  output logic                  bus_wr,
  output logic                  bus_rd,
  input  logic [WORD_W-1:0]     bus_rdata,
  input  logic                  bus_ready,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            resp
);
  localparam int NWORDS = 3;
  localparam int SUM_W  = AW + 2;

  seq_state_e            state;
  logic [AW-1:0]         ptr;
  logic [AW:0]           used;
  logic [AW:0]           lim_q;
  logic [WORD_W-1:0]     words [NWORDS];
  cmd_info_t             info;
  logic [WORD_W-1:0]     opa, opb, wdata_q;
  logic [DIR_OFFS_W-1:0] cur_addr;
  logic [SPACE_W-1:0]    cur_space;
  logic                  cur_ind;
  logic [SUM_W-1:0]      need;
  logic                  fits;
  logic                  poll_hit, poll_miss, poll_expire;

  cmdtab_table_mem #(.AW(AW), .DW(WORD_W), .NRD(NWORDS)) u_mem (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .rbase (ptr),
    .rdata (words)
  );

  cmdtab_decode u_dec (
    .hdr  (words[0]),
    .info (info)
  );

  assign poll_hit  = ((bus_rdata & opa) == opb);
  assign poll_miss = (state == ST_POLL) && bus_ready && !poll_hit;

  cmdtab_poll_budget #(.LIMIT(POLL_TRIES)) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state == ST_FETCH),
    .miss   (poll_miss),
    .expire (poll_expire)
  );

  assign need = SUM_W'(used) + SUM_W'(info.len);
  assign fits = need <= SUM_W'(lim_q);

  assign busy         = (state != ST_IDLE);
  assign bus_wr       = (state == ST_WRITE);
  assign bus_rd       = (state == ST_RMW_RD) || (state == ST_POLL);
  assign bus_addr     = cur_addr;
  assign bus_space    = cur_space;
  assign bus_indirect = cur_ind;
  assign bus_wdata    = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      used      <= '0;
      lim_q     <= '0;
      opa       <= '0;
      opb       <= '0;
      wdata_q   <= '0;
      cur_addr  <= '0;
      cur_space <= '0;
      cur_ind   <= 1'b0;
      done      <= 1'b0;
      resp      <= RESP_NONE;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ptr   <= start_base;
            used  <= '0;
            lim_q <= run_words;
            resp  <= RESP_NONE;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          cur_addr  <= info.addr;
          cur_space <= info.space;
          cur_ind   <= info.indirect;
          opa       <= words[1];
          opb       <= words[2];
          wdata_q   <= words[1];
          ptr       <= ptr + AW'(info.len);
          used      <= used + (AW+1)'(info.len);
          if (!fits) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            resp  <= RESP_INCOMPLETE;
          end else begin
            case (info.kind)
              CMD_WRITE: state <= ST_WRITE;
              CMD_RMW:   state <= ST_RMW_RD;
              CMD_POLL:  state <= ST_POLL;
              CMD_END: begin
                state <= ST_IDLE;
                done  <= 1'b1;
                resp  <= RESP_OK;
              end
              default: begin
                state <= ST_IDLE;
                done  <= 1'b1;
                resp  <= RESP_INCOMPLETE;
              end
            endcase
          end
        end
        ST_WRITE: begin
          if (bus_ready) state <= ST_FETCH;
        end
        ST_RMW_RD: begin
          if (bus_ready) begin
            wdata_q <= (bus_rdata & ~opb) | (opa & opb);
            state   <= ST_WRITE;
          end
        end
        ST_POLL: begin
          if (bus_ready) begin
            if (poll_hit) begin
              state <= ST_FETCH;
            end else if (poll_expire) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              resp  <= RESP_INCOMPLETE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdtab_seq_chk.sv
module cmdtab_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_ready,
  input logic [27:0] bus_addr,
  input logic [7:0]  bus_space,
  input logic [31:0] bus_wdata,
  input logic        busy,
  input logic        done,
  input logic [1:0]  resp
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_wr && !bus_rd));

  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_ready) |=>
      (bus_wr == $past(bus_wr)) && (bus_rd == $past(bus_rd)) &&
      $stable(bus_addr) && $stable(bus_space) && $stable(bus_wdata));

  assert_done_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (resp == 2'd1 || resp == 2'd2));

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_takes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && resp == 2'd0));
endmodule

bind cmdtab_seq cmdtab_seq_chk u_chk (.*);

// File: tb/cmdtab_seq_bench.sv
module cmdtab_seq_bench;
  localparam int AW = 6;
  localparam int TRIES = 8;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_base = '0;
  logic [AW:0] run_words = '0;
  logic tbl_we = 1'b0;
  logic [AW-1:0] tbl_waddr = '0;
  logic [31:0] tbl_wdata = '0;
  logic [27:0] bus_addr;
  logic [7:0] bus_space;
  logic bus_indirect;
  logic [31:0] bus_wdata;
  logic bus_wr, bus_rd;
  logic [31:0] bus_rdata;
  logic bus_ready = 1'b0;
  logic busy, done;
  logic [1:0] resp;

  always #10 clk = ~clk;

  cmdtab_seq #(.AW(AW), .POLL_TRIES(TRIES)) u_cmdtab_seq (.*);

  int n_chk = 0, n_err = 0;
  bit stall_en = 1'b0;

  // slave register model owned by the bench
  logic [31:0] sregs [16];
  logic [31:0] scnt;
  int ind_n;
  logic [27:0] ind_addr;
  logic [7:0] ind_space;
  logic [31:0] ind_data;

  assign bus_rdata = (!bus_indirect && bus_addr == 28'd31) ? scnt : sregs[bus_addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) sregs[i] <= 32'h0101_0101 * i;
      scnt <= 32'h0000_00F0;
      ind_n <= 0;
      ind_addr <= '0;
      ind_space <= '0;
      ind_data <= '0;
    end else if (bus_ready && (bus_wr || bus_rd)) begin
      if (bus_wr && bus_indirect) begin
        ind_n <= ind_n + 1;
        ind_addr <= bus_addr;
        ind_space <= bus_space;
        ind_data <= bus_wdata;
      end else if (bus_wr) begin
        sregs[bus_addr[3:0]] <= bus_wdata;
      end
      if (bus_rd && bus_addr == 28'd31) scnt <= scnt + 1;
    end
    bus_ready <= stall_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // table image and reference walk
  logic [31:0] tb_mem [DEPTH];
  logic [31:0] m_regs [16];
  logic [31:0] m_cnt;
  int m_ind_n;
  logic [27:0] m_ind_addr;
  logic [7:0] m_ind_space;
  logic [31:0] m_ind_data;
  logic [1:0] m_resp;

  task automatic put(input int idx, input logic [31:0] v);
    tb_mem[idx % DEPTH] = v;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_run(input int base, input int lim);
    int p = base;
    int used = 0;
    m_regs = sregs;
    m_cnt = scnt;
    m_ind_n = ind_n;
    m_ind_addr = ind_addr;
    m_ind_space = ind_space;
    m_ind_data = ind_data;
    forever begin
      logic [31:0] hdr, w1, w2, v;
      logic [3:0] op;
      int len;
      bit ok;
      hdr = tb_mem[p % DEPTH];
      w1 = tb_mem[(p + 1) % DEPTH];
      w2 = tb_mem[(p + 2) % DEPTH];
      op = hdr[31:28];
      len = (op == 4'h0 || op == 4'h8) ? 2 : (op == 4'h2 || op == 4'h3) ? 3 : 1;
      if (used + len > lim) begin m_resp = 2'd2; return; end
      case (op)
        4'hF: begin m_resp = 2'd1; return; end
        4'h0: m_regs[hdr[3:0]] = w1;
        4'h8: begin
          m_ind_n++;
          m_ind_addr = {8'h0, hdr[19:0]};
          m_ind_space = hdr[27:20];
          m_ind_data = w1;
        end
        4'h3: m_regs[hdr[3:0]] = (m_regs[hdr[3:0]] & ~w2) | (w1 & w2);
        4'h2: begin
          ok = 1'b0;
          for (int t = 0; t < TRIES; t++) begin
            v = (hdr[27:0] == 28'd31) ? m_cnt : m_regs[hdr[3:0]];
            if (hdr[27:0] == 28'd31) m_cnt++;
            if ((v & w1) == w2) begin ok = 1'b1; break; end
          end
          if (!ok) begin m_resp = 2'd2; return; end
        end
        default: begin m_resp = 2'd2; return; end
      endcase
      p += len;
      used += len;
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      tbl_we = 1'b1;
      tbl_waddr = AW'(i);
      tbl_wdata = tb_mem[i];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic pulse_start(input int base, input int lim);
    @(negedge clk);
    start = 1'b1;
    start_base = AW'(base);
    run_words = (AW+1)'(lim);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(req, "done seen", {31'b0, done}, 32'd1);
    chk("R12", "busy low with done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R12", "done single cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    chk(req, "resp", {30'b0, resp}, {30'b0, m_resp});
    for (int i = 0; i < 16; i++) if (sregs[i] !== m_regs[i]) bad++;
    chk(req, "register mismatches", bad, 0);
    chk(req, "poll counter", scnt, m_cnt);
    chk(req, "indirect count", ind_n, m_ind_n);
    chk(req, "indirect last", {ind_addr[23:0], ind_space} ^ ind_data,
        {m_ind_addr[23:0], m_ind_space} ^ m_ind_data);
  endtask

  task automatic run(input int base, input int lim, input string req);
    load_all();
    model_run(base, lim);
    pulse_start(base, lim);
    wait_done(req);
    compare_all(req);
  endtask

  task automatic gen_rand(input int base, output int lim);
    int p = 0;
    int n = 1 + ($urandom % 6);
    int tail;
    for (int i = 0; i < DEPTH; i++) tb_mem[i] = $urandom;
    for (int k = 0; k < n; k++) begin
      int c = $urandom % 4;
      logic [3:0] r = 4'($urandom);
      case (c)
        0: begin put(base + p, {4'h0, 24'h0, r}); put(base + p + 1, $urandom); p += 2; end
        1: begin put(base + p, {4'h3, 24'h0, r}); put(base + p + 1, $urandom);
                 put(base + p + 2, $urandom); p += 3; end
        2: begin put(base + p, {4'h2, 28'd31}); put(base + p + 1, 32'hF);
                 put(base + p + 2, $urandom % 16); p += 3; end
        default: begin put(base + p, {4'h8, 8'($urandom), 20'($urandom)});
                 put(base + p + 1, $urandom); p += 2; end
      endcase
    end
    tail = $urandom % 8;
    if (tail == 0) begin put(base + p, {4'h6, 28'h0}); p += 1; end
    else if (tail != 1) begin put(base + p, {4'hF, 28'h0}); p += 1; end
    lim = (tail == 2) ? p - 1 : p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] old, c;
    int lim;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) tb_mem[i] = {4'hF, 28'h0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'b0, busy}, 0);
    chk("R1", "done", {31'b0, done}, 0);
    chk("R1", "resp", {30'b0, resp}, 0);
    chk("R1", "requests", {30'b0, bus_wr, bus_rd}, 0);

    // R2 direct write then R7 end
    put(10, {4'h0, 28'd3}); put(11, 32'hA5A5_0F0F); put(12, {4'hF, 28'h0});
    run(10, 3, "R2");
    chk("R2", "reg3", sregs[3], 32'hA5A5_0F0F);
    chk("R7", "resp ok", {30'b0, resp}, 32'd1);

    // R3 indirect write fields
    put(20, {4'h8, 8'h3C, 20'h12345}); put(21, 32'hCAFE_F00D); put(22, {4'hF, 28'h0});
    run(20, 3, "R3");
    chk("R3", "indirect addr", {4'h0, ind_addr}, 32'h0001_2345);
    chk("R3", "indirect space", {24'h0, ind_space}, 32'h3C);
    chk("R3", "indirect data", ind_data, 32'hCAFE_F00D);

    // R4 read-modify-write merge
    old = sregs[5];
    put(30, {4'h3, 28'd5}); put(31, 32'h1234_5678); put(32, 32'h0000_FFFF); put(33, {4'hF, 28'h0});
    run(30, 4, "R4");
    chk("R4", "reg5 merged", sregs[5], (old & 32'hFFFF_0000) | 32'h0000_5678);

    // R5 poll meets wait value on the fourth read
    c = scnt;
    put(40, {4'h2, 28'd31}); put(41, 32'hFF); put(42, (c + 3) & 32'hFF); put(43, {4'hF, 28'h0});
    run(40, 4, "R5");
    chk("R5", "reads made", scnt - c, 32'd4);
    chk("R5", "resp ok", {30'b0, resp}, 32'd1);

    // R6 poll gives up after TRIES misses
    c = scnt;
    put(40, {4'h2, 28'd31}); put(41, 32'hFF); put(42, (c + TRIES) & 32'hFF); put(43, {4'hF, 28'h0});
    run(40, 4, "R6");
    chk("R6", "reads made", scnt - c, TRIES);
    chk("R6", "resp incomplete", {30'b0, resp}, 32'd2);

    // R8 unknown code stops before the following write
    old = sregs[7];
    put(50, {4'h5, 28'd7}); put(51, {4'h0, 28'd7}); put(52, 32'h7777_0000); put(53, {4'hF, 28'h0});
    run(50, 10, "R8");
    chk("R8", "reg7 untouched", sregs[7], old);
    chk("R8", "resp incomplete", {30'b0, resp}, 32'd2);

    // R9 budget too small for the first command
    old = sregs[9];
    put(0, {4'h0, 28'd9}); put(1, 32'h9999_9999); put(2, {4'hF, 28'h0});
    run(0, 1, "R9");
    chk("R9", "reg9 untouched", sregs[9], old);
    chk("R9", "resp incomplete", {30'b0, resp}, 32'd2);

    // R10 chain of every length across the table wrap
    put(62, {4'h0, 28'd2}); put(63, 32'h0BAD_F00D);
    put(0, {4'h3, 28'd2}); put(1, 32'hFFFF_FFFF); put(2, 32'h0000_00FF);
    put(3, {4'h8, 8'h11, 20'h00ABC}); put(4, 32'h1357_2468);
    put(5, {4'hF, 28'h0});
    run(62, 8, "R10");
    chk("R10", "reg2 after chain", sregs[2], 32'h0BAD_F0FF);
    chk("R10", "resp ok", {30'b0, resp}, 32'd1);

    // R12 start while busy is ignored
    c = scnt;
    put(40, {4'h2, 28'd31}); put(41, 32'hFF); put(42, (c + TRIES) & 32'hFF); put(43, {4'hF, 28'h0});
    put(10, {4'h0, 28'd12}); put(11, 32'h1212_1212); put(12, {4'hF, 28'h0});
    load_all();
    model_run(40, 4);
    pulse_start(40, 4);
    repeat (2) @(negedge clk);
    start = 1'b1; start_base = AW'(10); run_words = 7'd3;
    @(negedge clk);
    start = 1'b0;
    wait_done("R12");
    compare_all("R12");

    // random tables with a stalling slave
    stall_en = 1'b1;
    for (int t = 0; t < 40; t++) begin
      int b = $urandom % DEPTH;
      gen_rand(b, lim);
      run(b, lim, "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule